// File: doc/BRIEF.md
# Two-phase self-timed FIFO pipeline

This block is a first-in first-out pipeline built as a linear chain of stages that move words forward by local handshakes alone. No write pointer, read pointer or occupancy counter exists. Each stage owns one data register and one control bit. The control bit is a Muller C-element. It combines the request from the stage behind with the inverted acknowledge from the stage ahead. It copies its request input only when the two inputs agree, and otherwise it holds.

Both edges of the pipe use transition signalling. A toggle of `in_req`, rising or falling, offers one word. A toggle of `in_ack` takes it. A toggle of `out_req` presents one word, and a toggle of `out_ack` from the consumer releases it. The control bit of a stage acts as the acknowledge to the stage behind and as the request to the stage ahead. A stage loads its data register on the edge where its control bit flips. The C-elements are modelled behaviourally: each one is evaluated once per `clk` edge, so a word moves one stage per edge.

The fill level of the pipe shows in the pattern of control bits, brought out on `stage_state`. When every bit matches `out_ack`, the pipe is empty. When neighbouring bits alternate, the pipe is full.

Top module: `toggle_pipe_fifo`

## Requirements
- R1: While `rst` is high, every control bit, `in_ack`, `out_req` and `out_data` go to 0 on the next clock edge. This is the empty state.
- R2: A stage's control bit changes only on an edge where its request input differs from its acknowledge-from-ahead input, and it then takes the request value. From reset, with one word offered and a stalled consumer, `stage_state` reads `(1<<k)-1` after k edges. Bit i of `stage_state` is stage i, and stage 0 is the input end.
- R3: `in_ack` toggles only after `in_req` differs from it. `out_req` toggles only while it equals `out_ack`. Each accepted toggle carries exactly one word.
- R4: Words leave in the order they were accepted, with none lost and none duplicated, under any timing of sender and receiver.
- R5: While `out_req` differs from `out_ack`, `out_data` holds the oldest word in the pipe and does not change. A stage's data register changes only on an edge where its control bit flips.
- R6: With no word in flight, every bit of `stage_state` equals `out_ack`. While no new request is pending, `stage_state` stays unchanged.
- R7: With the consumer stalled and DEPTH words accepted, bit i of `stage_state` equals `out_ack` XOR ((DEPTH-i) is odd). A further request toggle is then not acknowledged until the consumer releases a word.
- R8: On an empty pipe, `in_ack` answers a request toggle at the first clock edge, and `out_req` toggles at the DEPTH-th edge.
- R9: Two adjacent stages never flip on the same edge. Acceptance at the input and a new word at the output may fall on the same edge, and neither disturbs the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Evaluation clock for the behavioural C-elements |
| rst | input | 1 | Synchronous active-high reset |
| in_req | input | 1 | Sender request; each toggle offers one word |
| in_data | input | WIDTH | Word offered; must stay stable until `in_ack` toggles |
| in_ack | output | 1 | Toggles when the first stage takes the word |
| out_req | output | 1 | Toggles when a new word is presented |
| out_data | output | WIDTH | Word held by the last stage |
| out_ack | input | 1 | Consumer acknowledge; each toggle releases one word |
| stage_state | output | DEPTH | Control bit of every stage, bit 0 at the input end |

## Verification
Acceptance of a new word at the first stage and arrival of a word at the last stage can happen on the same edge. This happens once several words are in flight. The bench provokes it by running sender and receiver with independent random delays of zero to three cycles. It counts the edges on which `in_ack` and `out_req` both toggle. On every clock it compares the presented word with the head of a behavioural queue, and it checks that no two neighbouring control bits flipped together. At the end the coincidence count must be non-zero, the queue must be empty, and the control pattern must have returned to the empty state.

// File: rtl/toggle_pipe_pkg.sv
package toggle_pipe_pkg;

  // Behavioural Muller C-element: follow the inputs when they agree, else hold.
  function automatic logic c_elem_next(input logic a, input logic b, input logic q);
    return (a == b) ? a : q;
  endfunction

endpackage

// File: rtl/tp_celem.sv
module tp_celem
  import toggle_pipe_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic a,
  input  logic b,
  output logic q,
  output logic flip
);

  logic q_nxt;

  assign q_nxt = c_elem_next(a, b, q);
  assign flip  = (q_nxt != q);

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= q_nxt;
  end

endmodule

// File: rtl/tp_stage.sv
module tp_stage #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fwd_req,
  input  logic             bwd_ack,
  input  logic [WIDTH-1:0] d_in,
  output logic             ctl_q,
  output logic [WIDTH-1:0] d_q
);

  logic ack_n;
  logic flip;

  assign ack_n = ~bwd_ack;

  tp_celem u_celem (
    .clk  (clk),
    .rst  (rst),
    .a    (fwd_req),
    .b    (ack_n),
    .q    (ctl_q),
    .flip (flip)
  );

  // Data register loads on the edge where the control bit flips.
  always_ff @(posedge clk) begin
    if (rst)       d_q <= '0;
    else if (flip) d_q <= d_in;
  end

  AST_CTL_STEP: assert property (@(posedge clk) disable iff (rst)
    !$stable(ctl_q) |-> ($past(fwd_req != bwd_ack) && (ctl_q == $past(fwd_req))))
    else $error("control bit moved while its inputs disagreed"); // R2

  AST_DATA_WITH_CTL: assert property (@(posedge clk) disable iff (rst)
    !$stable(d_q) |-> !$stable(ctl_q))
    else $error("data register changed without a control flip"); // R5

endmodule

// File: rtl/toggle_pipe_fifo.sv
module toggle_pipe_fifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_req,
  input  logic [WIDTH-1:0] in_data,
  output logic             in_ack,
  output logic             out_req,
  output logic [WIDTH-1:0] out_data,
  input  logic             out_ack,
  output logic [DEPTH-1:0] stage_state
);

  localparam int LAST = DEPTH - 1;

  logic [DEPTH-1:0] ctl;
  logic [DEPTH-1:0] fwd;
  logic [DEPTH-1:0] bwd;
  logic [WIDTH-1:0] dreg [DEPTH];

  // Request into stage i comes from behind, acknowledge from the stage ahead.
  assign fwd = {ctl[LAST-1:0], in_req};
  assign bwd = {out_ack, ctl[LAST:1]};

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      if (i == 0) begin : g_head
        tp_stage #(.WIDTH(WIDTH)) u_stage (
          .clk     (clk),
          .rst     (rst),
          .fwd_req (fwd[i]),
          .bwd_ack (bwd[i]),
          .d_in    (in_data),
          .ctl_q   (ctl[i]),
          .d_q     (dreg[i])
        );
      end else begin : g_body
        tp_stage #(.WIDTH(WIDTH)) u_stage (
          .clk     (clk),
          .rst     (rst),
          .fwd_req (fwd[i]),
          .bwd_ack (bwd[i]),
          .d_in    (dreg[i-1]),
          .ctl_q   (ctl[i]),
          .d_q     (dreg[i])
        );
      end
    end
  endgenerate

  assign in_ack      = ctl[0];
  assign out_req     = ctl[LAST];
  assign out_data    = dreg[LAST];
  assign stage_state = ctl;

  // Fill level read from the control pattern, used by the checks below.
  logic pipe_empty;
  logic pipe_full;
  assign pipe_empty = (ctl == {DEPTH{out_ack}});
  assign pipe_full  = (&(ctl[LAST:1] ^ ctl[LAST-1:0])) && (ctl[LAST] != out_ack);

  AST_RST_EMPTY: assert property (@(posedge clk)
    rst |=> (stage_state == '0 && !in_ack && !out_req && out_data == '0))
    else $error("reset did not empty the pipe"); // R1

  AST_IN_ACK_EVENT: assert property (@(posedge clk) disable iff (rst)
    !$stable(in_ack) |-> $past(in_req != in_ack))
    else $error("input acknowledge without a pending request"); // R3

  AST_OUT_REQ_EVENT: assert property (@(posedge clk) disable iff (rst)
    !$stable(out_req) |-> $past(out_req == out_ack))
    else $error("output request before the previous word was released"); // R3

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_req != out_ack) |=> $stable(out_data))
    else $error("presented word changed before release"); // R5

  AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (rst)
    (pipe_empty && in_req == in_ack) |=> $stable(stage_state))
    else $error("idle empty pipe changed state"); // R6

  AST_FULL_STALL: assert property (@(posedge clk) disable iff (rst)
    (pipe_full && in_req != in_ack) |=> $stable(in_ack))
    else $error("full pipe accepted a word"); // R7

  generate
    for (genvar j = 1; j < DEPTH; j++) begin : g_adj_chk
      AST_NO_ADJ_FIRE: assert property (@(posedge clk) disable iff (rst)
        !(!$stable(ctl[j]) && !$stable(ctl[j-1])))
        else $error("neighbouring stages flipped together"); // R9
    end
  endgenerate

endmodule

// File: tb/toggle_pipe_fifo_tb_top.sv
`timescale 1ns/1ps
module toggle_pipe_fifo_tb_top;

  localparam int DEPTH  = 4;
  localparam int WIDTH  = 8;
  localparam int NWORDS = 300;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_req = 1'b0;
  logic             out_ack = 1'b0;
  logic [WIDTH-1:0] in_data = '0;
  logic             in_ack;
  logic             out_req;
  logic [WIDTH-1:0] out_data;
  logic [DEPTH-1:0] stage_state;

  toggle_pipe_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut_i (
    .clk         (clk),
    .rst         (rst),
    .in_req      (in_req),
    .in_data     (in_data),
    .in_ack      (in_ack),
    .out_req     (out_req),
    .out_data    (out_data),
    .out_ack     (out_ack),
    .stage_state (stage_state)
  );

  always #2.5 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  int tx_cnt = 0;
  int rx_cnt = 0;
  int coincide = 0;
  logic [WIDTH-1:0] exp_q[$];

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic send_word(input logic [WIDTH-1:0] v);
    in_data = v;
    exp_q.push_back(v);
    in_req = ~in_req;
    tx_cnt++;
    do @(negedge clk); while (in_ack != in_req);
  endtask

  task automatic recv_word(input string req);
    while (out_req == out_ack) @(negedge clk);
    if (exp_q.size() == 0) chk(req, "word with empty model", 1, 0);
    else chk(req, "received word", out_data, exp_q.pop_front());
    rx_cnt++;
    out_ack = ~out_ack;
  endtask

  // Per-clock comparison against the behavioural queue.
  logic [DEPTH-1:0] prev_ss = '0;
  logic prev_ia = 1'b0;
  logic prev_or = 1'b0;
  always @(negedge clk) begin
    #1;
    if (!rst) begin
      if (out_req != out_ack) begin
        if (exp_q.size() > 0) chk("R5", "presented word vs model head", out_data, exp_q[0]);
        else chk("R4", "word presented with empty model", 1, 0);
      end
      chk("R9", "adjacent stages flipped together",
          (((stage_state ^ prev_ss) & ((stage_state ^ prev_ss) >> 1)) != '0), 0);
      if (in_ack != prev_ia && out_req != prev_or) coincide++;
    end
    prev_ss = stage_state;
    prev_ia = in_ack;
    prev_or = out_req;
  end

  initial begin
    logic [DEPTH-1:0] fp;
    logic [DEPTH-1:0] idle_ss;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "stage_state after reset", stage_state, 0);
    chk("R1", "in_ack after reset", in_ack, 0);
    chk("R1", "out_req after reset", out_req, 0);
    chk("R1", "out_data after reset", out_data, 0);

    // R2 / R8: one word travels through an empty pipe, consumer stalled.
    in_data = 8'hA5;
    exp_q.push_back(8'hA5);
    in_req = 1'b1;
    tx_cnt++;
    for (int k = 1; k <= DEPTH; k++) begin
      @(negedge clk);
      chk("R2", "stage pattern after k edges", stage_state, (1 << k) - 1);
      if (k == 1) chk("R8", "in_ack at first edge", in_ack, 1);
      if (k < DEPTH) chk("R8", "out_req before DEPTH edges", out_req, 0);
      else chk("R8", "out_req at DEPTH-th edge", out_req, 1);
    end
    recv_word("R4");
    repeat (3) @(negedge clk);
    chk("R6", "empty pattern after single word", stage_state, {DEPTH{out_ack}});
    idle_ss = stage_state;
    repeat (4) @(negedge clk);
    chk("R6", "idle pipe holds state", stage_state, idle_ss);

    // R7: fill with consumer stalled.
    for (int w = 0; w < DEPTH; w++) send_word(WIDTH'(8'h10 + w));
    repeat (DEPTH + 2) @(negedge clk);
    for (int i = 0; i < DEPTH; i++) fp[i] = out_ack ^ (((DEPTH - i) % 2) == 1);
    chk("R7", "full alternating pattern", stage_state, fp);
    in_data = 8'h77;
    exp_q.push_back(8'h77);
    in_req = ~in_req;
    tx_cnt++;
    repeat (5) @(negedge clk);
    chk("R7", "request left pending while full", in_ack != in_req, 1);
    chk("R7", "full pattern unchanged", stage_state, fp);
    recv_word("R7");
    while (in_ack != in_req) @(negedge clk);
    chk("R3", "pending request taken after release", in_ack, in_req);
    repeat (DEPTH) recv_word("R4");
    repeat (DEPTH + 2) @(negedge clk);
    chk("R6", "empty pattern after drain", stage_state, {DEPTH{out_ack}});
    chk("R4", "model empty after drain", exp_q.size(), 0);

    // R4 / R9: independent random sender and receiver.
    fork
      begin
        for (int w = 0; w < NWORDS; w++) begin
          repeat ($urandom_range(0, 3)) @(negedge clk);
          send_word(WIDTH'(w * 37 + 11));
        end
      end
      begin
        for (int w = 0; w < NWORDS; w++) begin
          repeat ($urandom_range(0, 3)) @(negedge clk);
          recv_word("R4");
        end
      end
    join
    repeat (DEPTH + 2) @(negedge clk);
    chk("R4", "received count equals sent count", rx_cnt, tx_cnt);
    chk("R4", "model empty after stream", exp_q.size(), 0);
    chk("R6", "empty pattern after stream", stage_state, {DEPTH{out_ack}});
    chk("R9", "input accept and output arrival shared an edge", coincide > 0, 1);
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL R4 watchdog: actual=running expected=finished");
    summary();
    $finish;
  end

endmodule